// File: doc/BRIEF.md
# Slot-Reclaiming Shared Memory Arbiter

This block shares one line-organised memory among eight requesting cores. A slot pointer steps through the cores in a fixed ring, one position per clock. The core that owns the current slot is always served when it has a request pending. This gives every core a fixed and guaranteed turn that nothing else on the chip can disturb.

Any core may also raise a priority flag. A flagged core that has a request pending may take a slot whose owner is idle, so that bandwidth which would otherwise be lost gets reused. When several flagged cores want the same spare slot, the one that has been waiting longest wins. Equal waits go to the lower index. Cores that keep the flag low see exactly the fixed ring timing. Each access moves one 128-bit line of four 32-bit words, written or read as a whole.

Top module: `slot_arbiter`

## Requirements
- R1: Core 0 owns the slot in the first cycle after reset is released. Ownership then passes to the next core on every clock, in the order 0,1,...,7 and back to 0.
- R2: A core that has a request pending in its own slot is granted in that slot, whatever the flags, requests or waiting time of the other cores.
- R3: A core with its flag low is granted only in its own slot, so a lone request from it waits for that slot.
- R4: When the owner of the current slot has no request pending, the slot goes in the same cycle to a flagged core with a request pending, if there is one.
- R5: Among flagged cores competing for a spare slot, the one with the most clock edges spent pending and ungranted wins.
- R6: When competing flagged cores have waited equally long, the lowest core index wins.
- R7: A change of a core's flag is used by the slot decision of the very cycle in which the new value is present. A pending core that becomes flagged can take a spare slot at once.
- R8: At most one grant is high in any cycle. A grant is high only for a core with a request pending, and it lasts one cycle per request.
- R9: A granted write stores all 128 bits of the core's write data in the addressed line. A granted read returns the stored line on `rdata` in the cycle after the grant. Word 0 of the line is in bits 31:0 and word 3 in bits 127:96.
- R10: The two low address bits do not take part in line selection. Addresses 0x14 and 0x17 reach the same line.
- R11: While reset is high no grant is given, `rdata` is zero and the waiting ages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Per-core request, held until granted |
| prio | input | 8 | Per-core priority flag for spare slots |
| we | input | 8 | Per-core write enable (1 write, 0 read) |
| addr | input | 64 | Per-core word address, 8 bits per core, core 0 in bits 7:0 |
| wdata | input | 1024 | Per-core write line, 128 bits per core, core 0 in bits 127:0 |
| grant | output | 8 | One-cycle grant pulse per core |
| rdata | output | 128 | Read line for the core granted in the previous cycle |

## Verification
The sharpest collision happens in one cycle, when the owner of a slot and an older flagged core both have requests pending. Only one of them may win, so the bench sets this up on purpose: a core waits through several foreign slots and is then flagged in the cycle its neighbour's slot opens with the neighbour requesting. The bench expects the owner to be served and the flagged core to be served in its own following slot. A second collision is a flag change that arrives in the same cycle as a spare slot. Two pending unflagged cores of different or equal age are flagged together when an idle owner's slot comes up, and the order of the grant cycles is compared with the age and index rules. A reference model in the bench predicts the grant vector every cycle during mixed random traffic, and a scoreboard queue holds the expected read lines.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned LINE_BITS  = WORD_BITS * LINE_WORDS;
  localparam int unsigned OFS_BITS   = $clog2(LINE_WORDS);
  typedef logic [LINE_BITS-1:0] line_t;
endpackage

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned SLOT_W  = $clog2(N_CORES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_CORES - 1);

  always_ff @(posedge clk) begin
    if (rst)                slot <= '0;
    else if (slot == LAST)  slot <= '0;
    else                    slot <= slot + 1'b1;
  end
endmodule

// File: rtl/wait_age.sv
module wait_age #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned AGE_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CORES-1:0]       req,
  input  logic [N_CORES-1:0]       grant,
  output logic [N_CORES*AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [AGE_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !req[c] || grant[c]) cnt <= '0;
      else if (cnt != AGE_MAX)        cnt <= cnt + 1'b1;
    end
    assign age[c*AGE_W +: AGE_W] = cnt;
  end
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned AGE_W   = 6,
  parameter int unsigned SLOT_W  = $clog2(N_CORES)
) (
  input  logic [SLOT_W-1:0]        slot,
  input  logic [N_CORES-1:0]       req,
  input  logic [N_CORES-1:0]       prio,
  input  logic [N_CORES*AGE_W-1:0] age,
  output logic [N_CORES-1:0]       grant,
  output logic [SLOT_W-1:0]        gidx,
  output logic                     gvalid
);
  logic [N_CORES-1:0] spare_cand;
  logic [AGE_W-1:0]   best_age;
  logic [SLOT_W-1:0]  best_idx;
  logic               best_ok;

  assign spare_cand = req & prio;

  // oldest flagged requester, strict compare keeps the lowest index on ties
  always_comb begin
    best_age = '0;
    best_idx = '0;
    best_ok  = 1'b0;
    for (int c = 0; c < N_CORES; c++) begin
      if (spare_cand[c] && (!best_ok || age[c*AGE_W +: AGE_W] > best_age)) begin
        best_age = age[c*AGE_W +: AGE_W];
        best_idx = SLOT_W'(c);
        best_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    grant  = '0;
    gidx   = slot;
    gvalid = 1'b0;
    if (req[slot]) begin
      grant[slot] = 1'b1;
      gvalid      = 1'b1;
    end else if (best_ok) begin
      grant[best_idx] = 1'b1;
      gidx            = best_idx;
      gvalid          = 1'b1;
    end
  end
endmodule

// File: rtl/line_mem.sv
module line_mem #(
  parameter int unsigned LINE_AW   = 6,
  parameter int unsigned LINE_BITS = 128,
  parameter int unsigned DEPTH     = 1 << LINE_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 we,
  input  logic [LINE_AW-1:0]   line,
  input  logic [LINE_BITS-1:0] wdata,
  output logic [LINE_BITS-1:0] rdata
);
  logic [LINE_BITS-1:0] mem [DEPTH];
  logic [LINE_BITS-1:0] rd_raw;

  // single-port, read-first: suits block RAM inference
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[line] <= wdata;
      rd_raw <= mem[line];
    end
  end

  logic rd_live;
  always_ff @(posedge clk) begin
    if (rst) rd_live <= 1'b0;
    else     rd_live <= 1'b1;
  end

  assign rdata = rd_live ? rd_raw : '0;
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned AGE_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_CORES-1:0]           req,
  input  logic [N_CORES-1:0]           prio,
  input  logic [N_CORES-1:0]           we,
  input  logic [N_CORES*ADDR_W-1:0]    addr,
  input  logic [N_CORES*LINE_BITS-1:0] wdata,
  output logic [N_CORES-1:0]           grant,
  output logic [LINE_BITS-1:0]         rdata
);
  localparam int unsigned SLOT_W  = $clog2(N_CORES);
  localparam int unsigned LINE_AW = ADDR_W - OFS_BITS;

  logic [SLOT_W-1:0]        slot;
  logic [N_CORES*AGE_W-1:0] age;
  logic [N_CORES-1:0]       pick;
  logic [SLOT_W-1:0]        gidx;
  logic                     gvalid;
  logic [LINE_AW-1:0]       sel_line;
  line_t                    sel_data;
  logic                     sel_we;

  slot_ring #(.N_CORES(N_CORES), .SLOT_W(SLOT_W)) u_ring (
    .clk(clk), .rst(rst), .slot(slot)
  );

  wait_age #(.N_CORES(N_CORES), .AGE_W(AGE_W)) u_age (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .age(age)
  );

  slot_pick #(.N_CORES(N_CORES), .AGE_W(AGE_W), .SLOT_W(SLOT_W)) u_pick (
    .slot(slot), .req(req), .prio(prio), .age(age),
    .grant(pick), .gidx(gidx), .gvalid(gvalid)
  );

  assign grant    = rst ? '0 : pick;
  assign sel_line = addr[32'(gidx) * ADDR_W + OFS_BITS +: LINE_AW];
  assign sel_data = wdata[32'(gidx) * LINE_BITS +: LINE_BITS];
  assign sel_we   = we[gidx];

  line_mem #(.LINE_AW(LINE_AW), .LINE_BITS(LINE_BITS)) u_mem (
    .clk(clk), .rst(rst), .en(gvalid && !rst), .we(sel_we),
    .line(sel_line), .wdata(sel_data), .rdata(rdata)
  );
endmodule

// File: rtl/slot_arb_chk.sv
module slot_arb_chk #(
  parameter int unsigned N_CORES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CORES-1:0] req,
  input logic [N_CORES-1:0] prio,
  input logic [N_CORES-1:0] grant
);
  localparam int unsigned SW = $clog2(N_CORES);
  logic [SW-1:0] own;

  // independent ring position (R1)
  always_ff @(posedge clk) begin
    if (rst)                           own <= '0;
    else if (own == SW'(N_CORES - 1))  own <= '0;
    else                               own <= own + 1'b1;
  end

  p_owner_wins_r2: assert property (@(posedge clk) disable iff (rst)
    req[own] |-> grant[own]);

  p_single_grant_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_quiet_in_reset_r11: assert property (@(posedge clk)
    rst |-> grant == '0);

  for (genvar c = 0; c < N_CORES; c++) begin : g_c
    p_unflagged_own_slot_r3: assert property (@(posedge clk) disable iff (rst)
      (grant[c] && !prio[c]) |-> own == SW'(c));

    p_spare_to_flagged_r4: assert property (@(posedge clk) disable iff (rst)
      (grant[c] && own != SW'(c)) |-> (prio[c] && !req[own]));

    p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
      grant[c] |-> req[c]);
  end
endmodule

bind slot_arbiter slot_arb_chk #(.N_CORES(N_CORES)) u_chk (
  .clk(clk), .rst(rst), .req(req), .prio(prio), .grant(grant)
);

// File: tb/slot_arbiter_bench.sv
`timescale 1ns/1ps
module slot_arbiter_bench;
  localparam int N = 8, AW = 8, LB = 128, AMAX = 63;

  logic          clk = 1'b0, rst = 1'b1;
  logic [N-1:0]  req = '0, prio = '0, we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*LB-1:0] wdata = '0;
  logic [N-1:0]  grant;
  logic [LB-1:0] rdata;

  always #2.5 clk = ~clk;

  slot_arbiter u_slot_arbiter (
    .clk(clk), .rst(rst), .req(req), .prio(prio), .we(we),
    .addr(addr), .wdata(wdata), .grant(grant), .rdata(rdata)
  );

  int checks = 0, errors = 0;
  int ref_slot = 0, cyc = 0;
  int age [N];
  int gcyc [N];
  int icyc [N];
  logic [N-1:0]  got = '0;
  logic [LB-1:0] refmem [64];
  logic [LB-1:0] last_rd [N];
  typedef struct { int core; logic [LB-1:0] data; } rd_t;
  rd_t rdq [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor + scoreboard
  always @(negedge clk) begin
    logic [N-1:0] e;
    int best;
    string tag;
    rd_t it;
    if (rst) begin
      chk(grant == '0, "R11", "grant during reset", LB'(grant), '0);
      chk(rdata == '0, "R11", "rdata during reset", rdata, '0);
      got = '0;
    end else begin
      if (rdq.size() > 0) begin
        it = rdq.pop_front();
        chk(rdata === it.data, "R9", "read line", rdata, it.data);
        last_rd[it.core] = rdata;
      end
      e = '0;
      if (req[ref_slot]) begin
        e[ref_slot] = 1'b1; tag = "R2";
      end else begin
        best = -1;
        for (int i = 0; i < N; i++)
          if (req[i] && prio[i] && (best < 0 || age[i] > age[best])) best = i;
        if (best >= 0) begin e[best] = 1'b1; tag = "R5"; end
        else tag = "R3";
      end
      chk(grant == e, tag, "grant vector", LB'(grant), LB'(e));
      got = grant;
      for (int i = 0; i < N; i++) if (grant[i]) begin
        gcyc[i] = cyc;
        if (we[i]) refmem[addr[i*AW+2 +: 6]] = wdata[i*LB +: LB];
        else begin
          it.core = i; it.data = refmem[addr[i*AW+2 +: 6]];
          rdq.push_back(it);
        end
      end
    end
  end

  task automatic step();
    bit r;
    @(posedge clk);
    r = rst;
    #1;
    if (!r) begin
      for (int i = 0; i < N; i++) begin
        if (req[i] && !got[i]) age[i] = (age[i] < AMAX) ? age[i] + 1 : AMAX;
        else age[i] = 0;
        if (got[i]) req[i] = 1'b0;
      end
      ref_slot = (ref_slot + 1) % N;
      cyc++;
    end
  endtask

  task automatic issue(input int c, input logic [AW-1:0] a, input bit w,
                       input logic [LB-1:0] d, input bit p);
    req[c] = 1'b1; we[c] = w; prio[c] = p;
    addr[c*AW +: AW] = a; wdata[c*LB +: LB] = d;
    icyc[c] = cyc;
  endtask

  task automatic wait_slot(input int k);
    while (ref_slot != k) step();
  endtask

  task automatic drain();
    while (req != '0) step();
    step(); step();
    prio = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LB-1:0] d;
    for (int i = 0; i < N; i++) age[i] = 0;
    repeat (4) step();
    rst = 1'b0;

    // R1: all cores write at once, served strictly in ring order
    wait_slot(3);
    for (int i = 0; i < N; i++)
      issue(i, AW'(i * 4), 1'b1, {4{32'hA000_0000 + 32'(i)}}, 1'b0);
    drain();
    for (int i = 0; i < N; i++)
      chk(gcyc[i] % N == i, "R1", "ring slot of core", LB'(gcyc[i] % N), LB'(i));

    // R9 / R10: write via 0x14, read via 0x17
    d = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_0000};
    issue(2, 8'h14, 1'b1, d, 1'b0); drain();
    issue(5, 8'h17, 1'b0, '0, 1'b0); drain();
    chk(last_rd[5] === d, "R10", "line via low bits", last_rd[5], d);

    // R3: lone unflagged request waits for its own slot
    wait_slot(6);
    issue(5, 8'h00, 1'b0, '0, 1'b0); drain();
    chk(gcyc[5] % N == 5, "R3", "unflagged slot", LB'(gcyc[5] % N), 5);
    chk(gcyc[5] - icyc[5] == 7, "R3", "unflagged wait", LB'(gcyc[5] - icyc[5]), 7);

    // R4: flagged request takes idle owner's slot at once
    wait_slot(1);
    issue(6, 8'h04, 1'b0, '0, 1'b1); drain();
    chk(gcyc[6] == icyc[6], "R4", "spare slot same cycle", LB'(gcyc[6] - icyc[6]), 0);

    // R5 + R7: older core wins once both become flagged
    wait_slot(0);
    issue(6, 8'h08, 1'b0, '0, 1'b0); step();
    issue(7, 8'h0C, 1'b0, '0, 1'b0); step();
    prio[6] = 1'b1; prio[7] = 1'b1;
    drain();
    chk(gcyc[6] % N == 2, "R7", "flag used at once", LB'(gcyc[6] % N), 2);
    chk(gcyc[7] % N == 3, "R5", "younger served later", LB'(gcyc[7] % N), 3);

    // R6: equal age, lower index first
    wait_slot(0);
    issue(5, 8'h10, 1'b0, '0, 1'b0);
    issue(3, 8'h18, 1'b0, '0, 1'b0); step();
    prio[3] = 1'b1; prio[5] = 1'b1;
    drain();
    chk(gcyc[3] % N == 1, "R6", "tie low index", LB'(gcyc[3] % N), 1);
    chk(gcyc[5] % N == 2, "R6", "tie high index", LB'(gcyc[5] % N), 2);

    // R2: owner beats an older flagged core in the same cycle
    wait_slot(4);
    issue(2, 8'h1C, 1'b0, '0, 1'b0);
    step();
    wait_slot(1);
    issue(1, 8'h00, 1'b0, '0, 1'b0); prio[2] = 1'b1;
    drain();
    chk(gcyc[1] % N == 1, "R2", "owner wins", LB'(gcyc[1] % N), 1);
    chk(gcyc[2] % N == 2, "R2", "flagged waits to own slot", LB'(gcyc[2] % N), 2);

    // mixed traffic, model checks every cycle (R8 single grant included)
    for (int t = 0; t < 400; t++) begin
      for (int c = 0; c < N; c++)
        if (!req[c] && ($urandom % 3 == 0))
          issue(c, AW'({$urandom % 8, 2'($urandom)}), 1'($urandom),
                {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
        else if (req[c] && ($urandom % 8 == 0))
          prio[c] = ~prio[c];
      step();
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule